// File: doc/BRIEF.md
# Time-Code Pulse Classifier and Frame Assembler

This block sits behind a radio time-code receiver front end that has already measured each carrier pulse in 25 ms ticks. Every measurement arrives as a one-cycle strobe carrying a 16-bit tick count. The block sorts each measurement into one of five kinds: a data 0, a data 1, the long gap that marks the start of a minute, a pulse too short to trust, or a length that matches nothing.

Data bits are written into a bit buffer at the position given by a running bit counter. A pulse that is too short, or a minute gap, sends the counter back to zero. The 59th data bit of a minute completes the frame. In the cycle that bit is stored, the buffer, with that last bit included, is copied to a held output frame, the counter returns to zero, and a sticky ready flag is raised. The flag stays high until the consumer acknowledges it.

Checking parity and decoding the time fields are left to the consumer of the frame.

Top module: `tc_pulse_frame`

## Requirements
- R1: After reset, bit_count is 0, frame_ready is 0 and frame_data is all zeros.
- R2: A strobe with a tick count of 0, 1 or 2 sets bit_count to 0 and does not raise frame_ready.
- R3: A strobe with a tick count of 3, 4 or 5 stores a 0 at the position bit_count names and increments bit_count by one.
- R4: A strobe with a tick count of 7, 8 or 9 stores a 1 at the position bit_count names and increments bit_count by one.
- R5: A strobe with a tick count from 40 to 83 inclusive (the minute gap) sets bit_count to 0.
- R6: A strobe with a tick count of 6, from 10 to 39, or 84 and above changes neither bit_count, frame_ready nor frame_data.
- R7: The bit stored at count n appears at frame_data[n], which is byte n/8, bit n mod 8.
- R8: When the data bit stored at count 58 arrives, bit_count becomes 0 and frame_ready becomes 1 on the clock edge that samples the strobe. On the same edge frame_data takes the buffer contents, including that bit.
- R9: frame_ready stays 1 until a cycle with frame_ack high clears it. If a frame completes in the same cycle as an acknowledge, frame_ready stays 1. frame_data changes only when a frame completes.
- R10: frame_data bits 59 to 63 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| pulse_valid | input | 1 | One-cycle strobe: pulse_ticks holds a new measurement |
| pulse_ticks | input | 16 | Pulse length in 25 ms ticks |
| frame_ack | input | 1 | Clears frame_ready |
| bit_count | output | 6 | Number of data bits collected in the current minute |
| frame_ready | output | 1 | Sticky flag: a complete frame is held in frame_data |
| frame_data | output | 64 | Last completed frame; bit n is the n-th data bit |

## Verification
The bench sends every tick count at the edge of each window: 2/3, 5/6/7, 9/10, 39/40 and 83/84, plus the largest 16-bit value. A design whose window bounds are off by one would either advance the counter or clear it on the wrong count.

It fills a complete minute and checks the copied frame bit for bit. A design that copied the frame one cycle early would lose bit 58, and one that completed on the 58th or 60th bit would leave bit_count and frame_ready out of step with the model.

An invalid pulse is sent in the middle of a minute before a full frame is collected. The bench also raises the acknowledge in the very cycle a frame completes, so a design that let the clear win would drop the ready flag.

// File: rtl/tc_pkg.sv
package tc_pkg;

  // Classification of one measured pulse.
  typedef enum logic [2:0] {
    PK_NONE   = 3'd0,  // no strobe this cycle
    PK_SHORT  = 3'd1,  // too short to trust: restart the minute
    PK_ZERO   = 3'd2,  // data bit 0
    PK_ONE    = 3'd3,  // data bit 1
    PK_SYNC   = 3'd4,  // minute gap: restart the minute
    PK_IGNORE = 3'd5   // matches no window: leave all state alone
  } pulse_kind_e;

endpackage

// File: rtl/tc_rst_sync.sv
module tc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/tc_pulse_sort.sv
module tc_pulse_sort
  import tc_pkg::*;
#(
  parameter int TICK_W   = 16,
  parameter int ZERO_MIN = 3,
  parameter int ZERO_MAX = 5,
  parameter int ONE_MIN  = 7,
  parameter int ONE_MAX  = 9,
  parameter int SYNC_MIN = 40,
  parameter int SYNC_MAX = 83
) (
  input  logic              valid_i,
  input  logic [TICK_W-1:0] ticks_i,
  output pulse_kind_e       kind_o
);

  localparam logic [TICK_W-1:0] ZLO = TICK_W'(ZERO_MIN);
  localparam logic [TICK_W-1:0] ZHI = TICK_W'(ZERO_MAX);
  localparam logic [TICK_W-1:0] OLO = TICK_W'(ONE_MIN);
  localparam logic [TICK_W-1:0] OHI = TICK_W'(ONE_MAX);
  localparam logic [TICK_W-1:0] SLO = TICK_W'(SYNC_MIN);
  localparam logic [TICK_W-1:0] SHI = TICK_W'(SYNC_MAX);

  logic in_zero;
  logic in_one;
  logic in_sync;

  always_comb begin
    in_zero = (ticks_i >= ZLO) && (ticks_i <= ZHI);
    in_one  = (ticks_i >= OLO) && (ticks_i <= OHI);
    in_sync = (ticks_i >= SLO) && (ticks_i <= SHI);
    if (!valid_i) begin
      kind_o = PK_NONE;
    end else if (ticks_i < ZLO) begin
      kind_o = PK_SHORT;
    end else if (in_zero) begin
      kind_o = PK_ZERO;
    end else if (in_one) begin
      kind_o = PK_ONE;
    end else if (in_sync) begin
      kind_o = PK_SYNC;
    end else begin
      kind_o = PK_IGNORE;
    end
  end

endmodule

// File: rtl/tc_bit_store.sv
module tc_bit_store
  import tc_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter int LAST_BIT   = 58,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  pulse_kind_e           kind_i,
  output logic [CNT_W-1:0]      bit_cnt_o,
  output logic [FRAME_BITS-1:0] bits_next_o,
  output logic                  complete_o
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LAST_BIT);

  logic [CNT_W-1:0]      cnt_q;
  logic [CNT_W-1:0]      cnt_d;
  logic [LAST_BIT:0]     bits_q;
  logic [FRAME_BITS-1:0] bits_d;
  logic                  store;
  logic                  bit_val;
  logic                  at_last;

  // Next-state: counter.
  always_comb begin
    store   = (kind_i == PK_ZERO) || (kind_i == PK_ONE);
    bit_val = (kind_i == PK_ONE);
    at_last = (cnt_q == LAST_IDX);
    case (kind_i)
      PK_SHORT, PK_SYNC: cnt_d = '0;
      PK_ZERO, PK_ONE:   cnt_d = at_last ? '0 : cnt_q + 1'b1;
      default:           cnt_d = cnt_q;
    endcase
  end

  // Next-state: one write-enabled slot per live bit; padding stays 0.
  for (genvar i = 0; i < FRAME_BITS; i++) begin : g_slot
    if (i <= LAST_BIT) begin : g_live
      logic wr;
      assign wr        = store && (cnt_q == CNT_W'(i));
      assign bits_d[i] = wr ? bit_val : bits_q[i];
    end else begin : g_pad
      assign bits_d[i] = 1'b0;
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (kind_i != PK_NONE) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (store) begin
      bits_q <= bits_d[LAST_BIT:0];
    end
  end

  assign bit_cnt_o   = cnt_q;
  assign bits_next_o = bits_d;
  assign complete_o  = store && at_last;

  // The counter never passes the last bit index.
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX);

  // A short pulse restarts the minute.
  p_short_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kind_i == PK_SHORT |=> cnt_q == '0);

  // A minute gap restarts the minute.
  p_sync_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kind_i == PK_SYNC |=> cnt_q == '0);

  // A data bit below the last index advances the count by one.
  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !at_last) |=> cnt_q == $past(cnt_q) + 1'b1);

  // An unmatched length leaves the count alone.
  p_ignore_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kind_i == PK_IGNORE |=> $stable(cnt_q));

  // The bit at the last index closes the minute.
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |=> cnt_q == '0);

endmodule

// File: rtl/tc_frame_latch.sv
module tc_frame_latch #(
  parameter int FRAME_BITS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  complete_i,
  input  logic [FRAME_BITS-1:0] bits_i,
  input  logic                  ack_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  ready_o
);

  logic [FRAME_BITS-1:0] frame_q;
  logic                  ready_q;
  logic                  ready_d;

  // Next-state: a completion wins over a clear in the same cycle.
  always_comb begin
    if (complete_i) begin
      ready_d = 1'b1;
    end else if (ack_i) begin
      ready_d = 1'b0;
    end else begin
      ready_d = ready_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (complete_i) begin
      frame_q <= bits_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready_d;
    end
  end

  assign frame_o = frame_q;
  assign ready_o = ready_q;

  // The flag is sticky until acknowledged.
  p_ready_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !ack_i) |=> ready_q);

  // A completion always leaves the flag set.
  p_ready_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    complete_i |=> ready_q);

  // The held frame moves only on a completion.
  p_frame_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !complete_i |=> $stable(frame_q));

endmodule

// File: rtl/tc_pulse_frame.sv
module tc_pulse_frame
  import tc_pkg::*;
#(
  parameter int TICK_W     = 16,
  parameter int FRAME_BITS = 64,
  parameter int LAST_BIT   = 58,
  parameter int ZERO_MIN   = 3,
  parameter int ZERO_MAX   = 5,
  parameter int ONE_MIN    = 7,
  parameter int ONE_MAX    = 9,
  parameter int SYNC_MIN   = 40,
  parameter int SYNC_MAX   = 83,
  parameter int RST_STAGES = 2,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pulse_valid,
  input  logic [TICK_W-1:0]     pulse_ticks,
  input  logic                  frame_ack,
  output logic [CNT_W-1:0]      bit_count,
  output logic                  frame_ready,
  output logic [FRAME_BITS-1:0] frame_data
);

  logic                  rst_sync_n;
  pulse_kind_e           kind;
  logic [FRAME_BITS-1:0] bits_next;
  logic                  complete;

  tc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tc_pulse_sort #(
    .TICK_W   (TICK_W),
    .ZERO_MIN (ZERO_MIN),
    .ZERO_MAX (ZERO_MAX),
    .ONE_MIN  (ONE_MIN),
    .ONE_MAX  (ONE_MAX),
    .SYNC_MIN (SYNC_MIN),
    .SYNC_MAX (SYNC_MAX)
  ) u_sort (
    .valid_i (pulse_valid),
    .ticks_i (pulse_ticks),
    .kind_o  (kind)
  );

  tc_bit_store #(
    .FRAME_BITS (FRAME_BITS),
    .LAST_BIT   (LAST_BIT)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .kind_i      (kind),
    .bit_cnt_o   (bit_count),
    .bits_next_o (bits_next),
    .complete_o  (complete)
  );

  tc_frame_latch #(.FRAME_BITS(FRAME_BITS)) u_latch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .complete_i (complete),
    .bits_i     (bits_next),
    .ack_i      (frame_ack),
    .frame_o    (frame_data),
    .ready_o    (frame_ready)
  );

  // Padding bits above the last data bit never carry data.
  if (FRAME_BITS - 1 > LAST_BIT) begin : g_pad_chk
    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
      frame_data[FRAME_BITS-1:LAST_BIT+1] == '0);
  end

endmodule

// File: tb/tc_pulse_frame_bench.sv
module tc_pulse_frame_bench;

  logic        clk;
  logic        rst_n;
  logic        pulse_valid;
  logic [15:0] pulse_ticks;
  logic        frame_ack;
  logic [5:0]  bit_count;
  logic        frame_ready;
  logic [63:0] frame_data;

  int compared;
  int mismatched;
  string cur_req;

  // Reference model state.
  int          m_cnt;
  logic [63:0] m_buf;
  logic [63:0] m_frame;
  logic        m_ready;

  tc_pulse_frame u_tc_pulse_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_valid (pulse_valid),
    .pulse_ticks (pulse_ticks),
    .frame_ack   (frame_ack),
    .bit_count   (bit_count),
    .frame_ready (frame_ready),
    .frame_data  (frame_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference, stepped on the same edge as the design.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_buf = '0; m_frame = '0; m_ready = 1'b0;
    end else begin
      bit done;
      int t;
      done = 1'b0;
      if (pulse_valid) begin
        t = int'(pulse_ticks);
        if (t < 3) m_cnt = 0;
        else if ((t >= 3 && t <= 5) || (t >= 7 && t <= 9)) begin
          m_buf[m_cnt] = (t >= 7);
          if (m_cnt >= 58) begin
            m_frame = m_buf; m_cnt = 0; done = 1'b1;
          end else m_cnt = m_cnt + 1;
        end else if (t > 39 && t < 84) m_cnt = 0;
      end
      if (done) m_ready = 1'b1;
      else if (frame_ack) m_ready = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare the whole state against the model every cycle, between edges.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, 64'(bit_count), 64'(m_cnt));
      chk(cur_req, 64'(frame_ready), 64'(m_ready));
      chk(cur_req, frame_data, m_frame);
    end
  end

  task automatic send(input int t, input bit ack = 1'b0);
    @(negedge clk);
    pulse_valid = 1'b1; pulse_ticks = 16'(t); frame_ack = ack;
    @(negedge clk);
    pulse_valid = 1'b0; pulse_ticks = '0; frame_ack = 1'b0;
  endtask

  task automatic send_bit(input bit b, input int k, input bit ack = 1'b0);
    send(b ? 7 + (k % 3) : 3 + (k % 3), ack);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); frame_ack = 1'b1;
    @(negedge clk); frame_ack = 1'b0;
  endtask

  task automatic full_frame(input logic [63:0] pat, input bit ack_last);
    for (int i = 0; i < 58; i++) send_bit(pat[i], i);
    chk("R8", 64'(bit_count), 64'd58);
    send_bit(pat[58], 58, ack_last);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [63:0] pa, pb;
    compared = 0; mismatched = 0; cur_req = "R1";
    rst_n = 1'b0; pulse_valid = 1'b0; pulse_ticks = '0; frame_ack = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    chk("R1", 64'(bit_count), 64'd0);
    chk("R1", 64'(frame_ready), 64'd0);
    chk("R1", frame_data, 64'd0);

    // R3: zero bits at every window value
    cur_req = "R3";
    send(3); send(4); send(5);
    chk("R3", 64'(bit_count), 64'd3);
    // R4: one bits at every window value
    cur_req = "R4";
    send(7); send(8); send(9);
    chk("R4", 64'(bit_count), 64'd6);

    // R6: unmatched lengths, window edges included
    cur_req = "R6";
    send(6); send(10); send(25); send(39); send(84); send(1000); send(65535);
    chk("R6", 64'(bit_count), 64'd6);
    chk("R6", 64'(frame_ready), 64'd0);
    chk("R6", frame_data, 64'd0);

    // R2: too-short pulses restart the count
    cur_req = "R2";
    send(2);
    chk("R2", 64'(bit_count), 64'd0);
    send(3); send(8); send(0);
    chk("R2", 64'(bit_count), 64'd0);
    send(4); send(1);
    chk("R2", 64'(bit_count), 64'd0);
    chk("R2", 64'(frame_ready), 64'd0);

    // R5: minute gap at both window edges
    cur_req = "R5";
    send(3); send(7); send(4); send(40);
    chk("R5", 64'(bit_count), 64'd0);
    send(9); send(5); send(83);
    chk("R5", 64'(bit_count), 64'd0);

    // R8 / R7 / R10: full minute
    cur_req = "R8";
    pa = 64'h0123_4567_89AB_CDEF & ((64'd1 << 59) - 1);
    full_frame(pa, 1'b0);
    chk("R8", 64'(bit_count), 64'd0);
    chk("R8", 64'(frame_ready), 64'd1);
    chk("R8", frame_data, pa);
    chk("R8", 64'(frame_data[58]), 64'(pa[58]));
    chk("R7", 64'(frame_data[15:8]), 64'(pa[15:8]));
    chk("R7", 64'(frame_data[58:56]), 64'(pa[58:56]));
    chk("R10", 64'(frame_data[63:59]), 64'd0);

    // R9: flag sticky until acknowledged, frame held
    cur_req = "R9";
    idle(5);
    chk("R9", 64'(frame_ready), 64'd1);
    send(3); send(7);
    chk("R9", 64'(frame_ready), 64'd1);
    chk("R9", frame_data, pa);
    pulse_ack();
    chk("R9", 64'(frame_ready), 64'd0);
    chk("R9", frame_data, pa);
    pulse_ack();
    chk("R9", 64'(frame_ready), 64'd0);

    // Partial minute broken by a short pulse, then a full minute whose
    // last bit coincides with an acknowledge.
    cur_req = "R2";
    for (int i = 0; i < 20; i++) send_bit(1'b1, i);
    send(1);
    chk("R2", 64'(bit_count), 64'd0);
    cur_req = "R9";
    pb = ~pa & ((64'd1 << 59) - 1);
    full_frame(pb, 1'b1);
    chk("R9", 64'(frame_ready), 64'd1);
    chk("R8", frame_data, pb);
    chk("R10", 64'(frame_data[63:59]), 64'd0);
    chk("R7", 64'(frame_data[7:0]), 64'(pb[7:0]));
    pulse_ack();
    chk("R9", 64'(frame_ready), 64'd0);

    // Sync then another full minute at once.
    cur_req = "R5";
    send(60);
    cur_req = "R8";
    full_frame(64'h0555_5555_5555_5555 & ((64'd1 << 59) - 1), 1'b0);
    chk("R8", frame_data, 64'h0555_5555_5555_5555 & ((64'd1 << 59) - 1));
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule